// File: doc/BRIEF.md
# Dual-Section Byte Transceiver with Parity Generation and Checking

This block joins two pairs of byte-wide buses and moves data between them in one direction at a time. Each section works on its own. It has two 8-bit sides, A and B, a direction input, an active-low enable and a select for odd or even parity. Each section also has a parity line whose direction follows the transfer. When sending, the section copies A onto B and drives a parity bit computed over A. When receiving, it copies B onto A, reads the parity line and pulls an active-low error flag when the nine bits have the wrong sense.

The block has no clock. Each tri-state side is split into three signals: a value in, a value out and a drive-enable. Surrounding pad logic, or a bench, resolves the bus from these. Each section decodes its inputs into one of three modes:

- OFF: the enable is inactive.
- SEND: the enable is active and the direction input is high.
- RECV: the enable is active and the direction input is low.

A section moves between modes as soon as its enable or direction input changes. Any mode can reach any other mode directly. `DATA_W` sets the bus width and `NUM_SECT` sets the number of sections. The defaults, 8 and 2, give a 16-bit device.

Top module: `xfer_dual_top`

## Requirements
- R1: With the enable low (active) and the direction bit high, the section is in SEND. It drives B (B drive-enable 1) with A's bits unchanged. The A drive-enable is 0.
- R2: With the enable low and the direction bit low, the section is in RECV. It drives A (A drive-enable 1) with B's bits unchanged. The B drive-enable is 0.
- R3: With the enable high, the section is in OFF. The A, B and parity drive-enables are all 0.
- R4: The parity select is 1 for odd and 0 for even. In SEND, the parity output makes the count of ones across the 8 A bits and the parity bit odd (select 1) or even (select 0). Example: even with five A bits high gives parity 1.
- R5: The parity drive-enable is 1 only in SEND. In every other mode the parity line is only read.
- R6: In RECV, the error flag is 0 exactly when the count of ones across the 8 B bits and the parity input fails the selected sense. Example: odd sense, parity input 1 and three B bits high gives flag 0.
- R7: In SEND and in OFF, the error flag is 1 whatever the parity input or B carry.
- R8: Any value output whose drive-enable is 0 reads as all zeros.
- R9: Each section responds only to its own inputs. Stimulus on one section leaves the other section's outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| oe_n | input | NUM_SECT | Active-low enable, one per section |
| dir_tx | input | NUM_SECT | 1 = A to B (SEND), 0 = B to A (RECV) |
| odd_sel | input | NUM_SECT | Parity sense: 1 odd, 0 even |
| a_in | input | NUM_SECT*DATA_W | A side value seen on the bus |
| a_out | output | NUM_SECT*DATA_W | A side value driven |
| a_drv | output | NUM_SECT | A side drive-enable |
| b_in | input | NUM_SECT*DATA_W | B side value seen on the bus |
| b_out | output | NUM_SECT*DATA_W | B side value driven |
| b_drv | output | NUM_SECT | B side drive-enable |
| par_in | input | NUM_SECT | Parity line value seen |
| par_out | output | NUM_SECT | Parity line value driven |
| par_drv | output | NUM_SECT | Parity line drive-enable |
| err_n | output | NUM_SECT | Active-low parity error flag |

## Verification
The hardest case to reach is a RECV mismatch in every parity class. It needs the B count, the parity input and the sense to disagree, and a bench that sweeps only the data value never toggles the parity line independently. The stimulus therefore walks all 256 B values against both parity-input levels under both senses. It does the same for all 256 A values in SEND. Meanwhile the other section holds a fixed mode, so any leakage between sections shows up on every cycle.

// File: rtl/xfer_pkg.sv
package xfer_pkg;

    typedef enum logic [1:0] {
        XFER_OFF  = 2'b00,
        XFER_SEND = 2'b01,
        XFER_RECV = 2'b10
    } xfer_mode_e;

endpackage

// File: rtl/xfer_mode_dec.sv
module xfer_mode_dec
    import xfer_pkg::*;
(
    input  logic       oe_n,
    input  logic       dir_tx,
    output xfer_mode_e mode
);

    always_comb begin
        unique case ({oe_n, dir_tx})
            2'b01:   mode = XFER_SEND;
            2'b00:   mode = XFER_RECV;
            default: mode = XFER_OFF;
        endcase
    end

endmodule

// File: rtl/xfer_parity_tree.sv
module xfer_parity_tree #(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] data,
    output logic              odd
);

    localparam int LEVELS = (DATA_W > 1) ? $clog2(DATA_W) : 0;
    localparam int PAD_W  = 1 << LEVELS;

    for (genvar k = 0; k <= LEVELS; k++) begin : lvl_g
        logic [(PAD_W >> k)-1:0] v;
        if (k == 0) begin : g_leaf
            assign v = PAD_W'(data);
        end else begin : g_node
            for (genvar j = 0; j < (PAD_W >> k); j++) begin : pair_g
                assign v[j] = lvl_g[k-1].v[2*j] ^ lvl_g[k-1].v[2*j+1];
            end
        end
    end

    assign odd = lvl_g[LEVELS].v[0];

endmodule

// File: rtl/xfer_slice.sv
module xfer_slice
    import xfer_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              oe_n,
    input  logic              dir_tx,
    input  logic              odd_sel,
    input  logic [DATA_W-1:0] a_in,
    output logic [DATA_W-1:0] a_out,
    output logic              a_drv,
    input  logic [DATA_W-1:0] b_in,
    output logic [DATA_W-1:0] b_out,
    output logic              b_drv,
    input  logic              par_in,
    output logic              par_out,
    output logic              par_drv,
    output logic              err_n
);

    xfer_mode_e mode;
    logic       a_odd;
    logic       b_odd;

    xfer_mode_dec u_dec (
        .oe_n   (oe_n),
        .dir_tx (dir_tx),
        .mode   (mode)
    );

    xfer_parity_tree #(.DATA_W(DATA_W)) u_par_a (
        .data (a_in),
        .odd  (a_odd)
    );

    xfer_parity_tree #(.DATA_W(DATA_W)) u_par_b (
        .data (b_in),
        .odd  (b_odd)
    );

    always_comb begin
        a_out   = '0;
        a_drv   = 1'b0;
        b_out   = '0;
        b_drv   = 1'b0;
        par_out = 1'b0;
        par_drv = 1'b0;
        err_n   = 1'b1;
        unique case (mode)
            XFER_SEND: begin
                b_out   = a_in;
                b_drv   = 1'b1;
                par_out = a_odd ^ odd_sel;
                par_drv = 1'b1;
            end
            XFER_RECV: begin
                a_out = b_in;
                a_drv = 1'b1;
                err_n = ~(b_odd ^ par_in ^ odd_sel);
            end
            default: begin
                err_n = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/xfer_dual_top.sv
module xfer_dual_top #(
    parameter int DATA_W   = 8,
    parameter int NUM_SECT = 2
) (
    input  logic [NUM_SECT-1:0]        oe_n,
    input  logic [NUM_SECT-1:0]        dir_tx,
    input  logic [NUM_SECT-1:0]        odd_sel,
    input  logic [NUM_SECT*DATA_W-1:0] a_in,
    output logic [NUM_SECT*DATA_W-1:0] a_out,
    output logic [NUM_SECT-1:0]        a_drv,
    input  logic [NUM_SECT*DATA_W-1:0] b_in,
    output logic [NUM_SECT*DATA_W-1:0] b_out,
    output logic [NUM_SECT-1:0]        b_drv,
    input  logic [NUM_SECT-1:0]        par_in,
    output logic [NUM_SECT-1:0]        par_out,
    output logic [NUM_SECT-1:0]        par_drv,
    output logic [NUM_SECT-1:0]        err_n
);

    for (genvar s = 0; s < NUM_SECT; s++) begin : sect_g
        xfer_slice #(.DATA_W(DATA_W)) u_slice (
            .oe_n    (oe_n[s]),
            .dir_tx  (dir_tx[s]),
            .odd_sel (odd_sel[s]),
            .a_in    (a_in[s*DATA_W +: DATA_W]),
            .a_out   (a_out[s*DATA_W +: DATA_W]),
            .a_drv   (a_drv[s]),
            .b_in    (b_in[s*DATA_W +: DATA_W]),
            .b_out   (b_out[s*DATA_W +: DATA_W]),
            .b_drv   (b_drv[s]),
            .par_in  (par_in[s]),
            .par_out (par_out[s]),
            .par_drv (par_drv[s]),
            .err_n   (err_n[s])
        );
    end

endmodule

// File: rtl/xfer_dual_chk.sv
module xfer_dual_chk #(
    parameter int DATA_W   = 8,
    parameter int NUM_SECT = 2
) (
    input logic [NUM_SECT-1:0]        oe_n,
    input logic [NUM_SECT-1:0]        dir_tx,
    input logic [NUM_SECT-1:0]        odd_sel,
    input logic [NUM_SECT*DATA_W-1:0] a_in,
    input logic [NUM_SECT*DATA_W-1:0] a_out,
    input logic [NUM_SECT-1:0]        a_drv,
    input logic [NUM_SECT*DATA_W-1:0] b_in,
    input logic [NUM_SECT*DATA_W-1:0] b_out,
    input logic [NUM_SECT-1:0]        b_drv,
    input logic [NUM_SECT-1:0]        par_in,
    input logic [NUM_SECT-1:0]        par_out,
    input logic [NUM_SECT-1:0]        par_drv,
    input logic [NUM_SECT-1:0]        err_n
);

    always_comb begin
        for (int s = 0; s < NUM_SECT; s++) begin
            AST_SEND_COPY: assert (!(b_drv[s]) || (b_out[s*DATA_W +: DATA_W] == a_in[s*DATA_W +: DATA_W])); // R1
            AST_RECV_COPY: assert (!(a_drv[s]) || (a_out[s*DATA_W +: DATA_W] == b_in[s*DATA_W +: DATA_W])); // R2
            AST_OFF_FLOAT: assert (!oe_n[s] || !(a_drv[s] | b_drv[s] | par_drv[s])); // R3
            AST_SEND_PARITY: assert (!par_drv[s] || ((^a_in[s*DATA_W +: DATA_W]) ^ par_out[s]) == odd_sel[s]); // R4
            AST_PAR_DRV_SEND: assert (par_drv[s] == b_drv[s]); // R5
            AST_RECV_CHECK: assert (!a_drv[s] || (err_n[s] == (((^b_in[s*DATA_W +: DATA_W]) ^ par_in[s]) == odd_sel[s]))); // R6
            AST_ERR_QUIET: assert (a_drv[s] || err_n[s]); // R7
            AST_ZERO_UNDRIVEN: assert ((a_drv[s] || a_out[s*DATA_W +: DATA_W] == '0) && (b_drv[s] || b_out[s*DATA_W +: DATA_W] == '0)); // R8
        end
    end

endmodule

bind xfer_dual_top xfer_dual_chk #(.DATA_W(DATA_W), .NUM_SECT(NUM_SECT)) u_chk (.*);

// File: tb/sim_xfer_dual_top.sv
module sim_xfer_dual_top;

    localparam int W  = 8;
    localparam int NS = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic [NS-1:0]   oe_n, dir_tx, odd_sel, par_in;
    logic [NS*W-1:0] a_in, b_in;
    logic [NS*W-1:0] a_out, b_out;
    logic [NS-1:0]   a_drv, b_drv, par_out, par_drv, err_n;

    int n_chk  = 0;
    int n_fail = 0;
    int cycles = 0;
    bit done   = 0;

    xfer_dual_top #(.DATA_W(W), .NUM_SECT(NS)) u0 (
        .oe_n(oe_n), .dir_tx(dir_tx), .odd_sel(odd_sel),
        .a_in(a_in), .a_out(a_out), .a_drv(a_drv),
        .b_in(b_in), .b_out(b_out), .b_drv(b_drv),
        .par_in(par_in), .par_out(par_out), .par_drv(par_drv),
        .err_n(err_n)
    );

    function automatic int ones(logic [W-1:0] v);
        int c = 0;
        for (int i = 0; i < W; i++) if (v[i]) c++;
        return c;
    endfunction

    task automatic chk(string req, int s, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s sect %0d: actual %0h expected %0h", req, s, act, exp);
        end
    endtask

    // Reference per section, from the requirements
    task automatic compare_all();
        for (int s = 0; s < NS; s++) begin
            logic [W-1:0] av = a_in[s*W +: W];
            logic [W-1:0] bv = b_in[s*W +: W];
            bit send = !oe_n[s] && dir_tx[s];
            bit recv = !oe_n[s] && !dir_tx[s];
            int want_odd = odd_sel[s] ? 1 : 0;
            int pbit = ((ones(av) % 2) != want_odd) ? 1 : 0;
            int rtot = (ones(bv) + (par_in[s] ? 1 : 0)) % 2;
            chk("R1 b_drv", s, 32'(b_drv[s]), 32'(send));
            chk("R1/R8 b_out", s, 32'(b_out[s*W +: W]), send ? 32'(av) : 32'd0);
            chk("R2 a_drv", s, 32'(a_drv[s]), 32'(recv));
            chk("R2/R8 a_out", s, 32'(a_out[s*W +: W]), recv ? 32'(bv) : 32'd0);
            chk("R3/R5 par_drv", s, 32'(par_drv[s]), 32'(send));
            if (send) chk("R4 par_out", s, 32'(par_out[s]), 32'(pbit));
            if (recv) chk("R6 err_n", s, 32'(err_n[s]), (rtot == want_odd) ? 32'd1 : 32'd0);
            else      chk("R7 err_n", s, 32'(err_n[s]), 32'd1);
        end
    endtask

    task automatic step();
        @(negedge clk);
        compare_all();
        @(posedge clk);
    endtask

    task automatic set_sect(int s, bit oen, bit dir, bit odd, bit pin,
                            logic [W-1:0] av, logic [W-1:0] bv);
        oe_n[s] = oen; dir_tx[s] = dir; odd_sel[s] = odd; par_in[s] = pin;
        a_in[s*W +: W] = av; b_in[s*W +: W] = bv;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected < 100000", cycles);
            finish_run();
        end
    end

    initial begin
        oe_n = '1; dir_tx = '0; odd_sel = '0; par_in = '0; a_in = '0; b_in = '0;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        // Reset state: both sections OFF (R3, R7, R8)
        step();
        // R3 OFF with busy data and parity line: nothing driven, flag high
        for (int s = 0; s < NS; s++) set_sect(s, 1, s[0], 1, 1, 8'hA5, 8'h3C);
        step();
        // Directed examples: R4 even, five ones -> parity 1
        set_sect(0, 0, 1, 0, 0, 8'b0001_1111, 8'h00);
        set_sect(1, 1, 0, 0, 0, 8'h00, 8'h00);
        step();
        chk("R4 example", 0, 32'(par_out[0]), 32'd1);
        // R6 odd, parity in 1, three ones -> flag low
        set_sect(0, 0, 0, 1, 1, 8'h00, 8'b0000_0111);
        step();
        chk("R6 example", 0, 32'(err_n[0]), 32'd0);
        // Sweeps; each section in turn, the other held in a fixed mode (R9)
        for (int s = 0; s < NS; s++) begin
            int o = 1 - s;
            for (int odd = 0; odd < 2; odd++) begin
                set_sect(o, 0, odd[0], 1, 1, 8'h5A, 8'hC3);
                for (int v = 0; v < 256; v++) begin
                    set_sect(s, 0, 1, odd[0], v[0], 8'(v), 8'(~v));
                    step();
                end
                for (int pin = 0; pin < 2; pin++) begin
                    for (int v = 0; v < 256; v++) begin
                        set_sect(s, 0, 0, odd[0], pin[0], 8'(~v), 8'(v));
                        step();
                    end
                end
                for (int v = 0; v < 256; v += 17) begin
                    set_sect(s, 1, v[1], odd[0], v[0], 8'(v), 8'(v + 3));
                    step();
                end
            end
        end
        // Mode changes straight from SEND to RECV and back (R1, R2)
        set_sect(0, 0, 1, 0, 1, 8'h81, 8'h7E); step();
        set_sect(0, 0, 0, 0, 1, 8'h81, 8'h7E); step();
        set_sect(0, 0, 1, 1, 0, 8'hFF, 8'h00); step();
        finish_run();
    end

endmodule